// File: doc/BRIEF.md
# Two-Wire Bus Controller Flag Tracker

This block keeps the hardware-maintained flag bits of a two-wire (SMBus/I2C) controller's control and status register. A separate bus engine produces one-cycle event strobes: START and STOP generated or seen on the wire, bytes finished, the ACK bit sampled, and the SDA/SCL conflicts found while driving. The block turns those strobes into eight flag bits. Each flag has its own rules for when it is set and when it is cleared.

Software can also write the register directly. When a hardware set and a software write touch the same flag in the same cycle, the hardware set wins, so no bus event is lost. While the serial interrupt flag is up, the block raises an interrupt line and tells the bus engine to hold SCL low. The bus then stalls until software clears the flag.

Top module: `smb_flag_tracker`

## Requirements
- R1: After synchronous reset all eight flags read 0, and `irq` and `sclHold` are low. The bit positions in `flags` and `swWrData` are: [0] master mode, [1] transmit mode, [2] start seen, [3] stop seen, [4] ACK request, [5] arbitration lost, [6] received ACK, [7] serial interrupt.
- R2: Master mode (bit 0) sets when a START is generated. It clears when a STOP is generated or when arbitration is lost.
- R3: Transmit mode (bit 1) sets when a START is generated. It also sets at a frame start if the data register was written at any time since the previous frame start, including the frame-start cycle itself. A frame start with no such write clears it. A detected START clears it, and so does a loss of arbitration.
- R4: Start seen (bit 2) sets when a START followed by an address byte is received. Only a software write clears it.
- R5: Stop seen (bit 3) sets when a STOP is detected while addressed as a slave; a STOP detected while not addressed leaves it at 0. It clears when a STOP is generated.
- R6: ACK request (bit 4) sets when a byte is received while hardware ACK generation is disabled; with it enabled the bit stays 0. It clears at the end of each ACK cycle.
- R7: Arbitration lost (bit 5) sets on any of three conditions. (a) A repeated START is detected while in master mode and start seen is 0. (b) SCL is sensed low while generating a STOP or repeated START. (c) SDA is sensed low while transmitting a 1 outside the ACK bit. A repeated START while start seen is 1, or while not in master mode, does not set it.
- R8: Arbitration lost clears whenever a software write takes the serial interrupt flag from 1 to 0.
- R9: Received ACK (bit 6) becomes 1 when the sampled ACK level is low and 0 when it is high.
- R10: The serial interrupt flag (bit 7) sets on any of these events: START generated, arbitration lost, byte transmitted with ACK/NACK received, byte received, START plus address received, or STOP received. No hardware event clears it. `irq` and `sclHold` both follow it.
- R11: When a hardware set event and a software write of 0 to the same flag occur in one cycle, the flag ends at 1.
- R12: With no hardware event in the cycle, a software write loads all eight flags from `swWrData` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| evStartGen | input | 1 | Controller generated a START |
| evStopGen | input | 1 | Controller generated a pending STOP |
| evStartDet | input | 1 | A START was detected on the bus |
| evRepStartDet | input | 1 | A repeated START was detected on the bus |
| evStopDet | input | 1 | A STOP was detected on the bus |
| evAddrRcvd | input | 1 | START followed by address and R/W byte received |
| evByteTxDone | input | 1 | Byte transmitted and its ACK/NACK received |
| evByteRx | input | 1 | Byte received |
| evAckSampled | input | 1 | Incoming ACK bit sampled this cycle |
| ackLevel | input | 1 | SDA level of the sampled ACK bit (0 = acknowledge) |
| evAckCycleEnd | input | 1 | An ACK cycle finished |
| evFrameStart | input | 1 | A frame begins (transmit-mode decision point) |
| sclLowOnGen | input | 1 | SCL sensed low while generating STOP or repeated START |
| sdaLowOnTx1 | input | 1 | SDA sensed low while sending a 1 (non-ACK bit) |
| dataWr | input | 1 | Data register write strobe |
| addressedSlave | input | 1 | Controller is currently addressed as a slave |
| hwAckEn | input | 1 | Hardware ACK generation enabled |
| swWrEn | input | 1 | Software write to the flag register |
| swWrData | input | 8 | Software write value |
| flags | output | 8 | Current flag bits |
| irq | output | 1 | Interrupt request |
| sclHold | output | 1 | Request to the bus engine to hold SCL low |

## Verification
The bench targets the points where flags interact. The first is the transmit-mode decision at frame start. A design that forgets a data write from an earlier cycle, or ignores one made in the frame-start cycle, shows receive mode for a frame that should transmit. Repeated STARTs are driven with start seen set and with master mode clear. A design that skips these qualifiers flags arbitration lost falsely.

Arbitration lost must clear through a software clear of the interrupt flag. A design that lacks this leaves the bit stuck. The bench also makes a hardware event and a software clear collide in one cycle. A design with the wrong priority drops the interrupt and releases SCL while an event is still unserviced.

// File: rtl/smbflag_pkg.sv
package smbflag_pkg;
  localparam int NFLAG = 8;
  localparam int MST = 0;
  localparam int TXM = 1;
  localparam int STA = 2;
  localparam int STO = 3;
  localparam int AKR = 4;
  localparam int ARB = 5;
  localparam int RXA = 6;
  localparam int SIF = 7;

  typedef struct packed {
    logic [NFLAG-1:0] hwSet;
    logic [NFLAG-1:0] hwClr;
  } flagStrobes_t;
endpackage

// File: rtl/smbflag_ctrl.sv
module smbflag_ctrl
  import smbflag_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         evStartGen,
  input  logic         evStopGen,
  input  logic         evStartDet,
  input  logic         evRepStartDet,
  input  logic         evStopDet,
  input  logic         evAddrRcvd,
  input  logic         evByteTxDone,
  input  logic         evByteRx,
  input  logic         evAckSampled,
  input  logic         ackLevel,
  input  logic         evAckCycleEnd,
  input  logic         evFrameStart,
  input  logic         sclLowOnGen,
  input  logic         sdaLowOnTx1,
  input  logic         dataWr,
  input  logic         addressedSlave,
  input  logic         hwAckEn,
  input  logic         masterQ,
  input  logic         startQ,
  output flagStrobes_t strb
);
  logic txPending;
  logic txPendingNext;
  logic arbEv;
  logic txChoice;

  // remember a data write until the next frame start consumes it
  always_comb begin
    txPendingNext = txPending;
    if (evFrameStart)  txPendingNext = 1'b0;
    else if (dataWr)   txPendingNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) txPending <= 1'b0;
    else     txPending <= txPendingNext;
  end

  assign txChoice = txPending | dataWr;

  // three independent arbitration-loss conditions (R7)
  assign arbEv = (evRepStartDet & masterQ & ~startQ) | sclLowOnGen | sdaLowOnTx1;

  always_comb begin
    strb = '0;
    strb.hwSet[MST] = evStartGen;
    strb.hwClr[MST] = evStopGen | arbEv;

    strb.hwSet[TXM] = evStartGen | (evFrameStart & txChoice);
    strb.hwClr[TXM] = evStartDet | arbEv | (evFrameStart & ~txChoice);

    strb.hwSet[STA] = evAddrRcvd;

    strb.hwSet[STO] = evStopDet & addressedSlave;
    strb.hwClr[STO] = evStopGen;

    strb.hwSet[AKR] = evByteRx & ~hwAckEn;
    strb.hwClr[AKR] = evAckCycleEnd;

    strb.hwSet[ARB] = arbEv;

    strb.hwSet[RXA] = evAckSampled & ~ackLevel;
    strb.hwClr[RXA] = evAckSampled & ackLevel;

    strb.hwSet[SIF] = evStartGen | arbEv | evByteTxDone | evByteRx |
                      evAddrRcvd | evStopDet;
  end

  // R3: a write made before a frame is still pending when that frame starts
  p_pending_held_r3: assert property (@(posedge clk) disable iff (rst)
    (dataWr && !evFrameStart) |=> txPending);
endmodule

// File: rtl/smbflag_regs.sv
module smbflag_regs
  import smbflag_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  flagStrobes_t     strb,
  input  logic             swWrEn,
  input  logic [NFLAG-1:0] swWrData,
  output logic [NFLAG-1:0] flagQ
);
  logic siSwClear;
  logic [NFLAG-1:0] extraClr;

  // a software write that drops the interrupt flag, unless hardware re-raises it
  assign siSwClear = swWrEn & flagQ[SIF] & ~swWrData[SIF] & ~strb.hwSet[SIF];

  always_comb begin
    extraClr = '0;
    extraClr[ARB] = siSwClear;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_bit
    logic nextBit;
    always_comb begin
      nextBit = swWrEn ? swWrData[i] : flagQ[i];
      if (strb.hwClr[i] | extraClr[i]) nextBit = 1'b0;
      if (strb.hwSet[i])               nextBit = 1'b1;
    end
    always_ff @(posedge clk) begin
      if (rst) flagQ[i] <= 1'b0;
      else     flagQ[i] <= nextBit;
    end
  end

  // R10: the interrupt flag never falls without a software write
  p_si_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (flagQ[SIF] && !swWrEn) |=> flagQ[SIF]);

  // R11: a hardware set survives a simultaneous software clear
  p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (strb.hwSet[SIF] && swWrEn && !swWrData[SIF]) |=> flagQ[SIF]);

  // R8: dropping the interrupt flag by software drops arbitration lost
  p_arb_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (siSwClear && !strb.hwSet[ARB]) |=> !flagQ[ARB]);
endmodule

// File: rtl/smb_flag_tracker.sv
module smb_flag_tracker
  import smbflag_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             evStartGen,
  input  logic             evStopGen,
  input  logic             evStartDet,
  input  logic             evRepStartDet,
  input  logic             evStopDet,
  input  logic             evAddrRcvd,
  input  logic             evByteTxDone,
  input  logic             evByteRx,
  input  logic             evAckSampled,
  input  logic             ackLevel,
  input  logic             evAckCycleEnd,
  input  logic             evFrameStart,
  input  logic             sclLowOnGen,
  input  logic             sdaLowOnTx1,
  input  logic             dataWr,
  input  logic             addressedSlave,
  input  logic             hwAckEn,
  input  logic             swWrEn,
  input  logic [NFLAG-1:0] swWrData,
  output logic [NFLAG-1:0] flags,
  output logic             irq,
  output logic             sclHold
);
  flagStrobes_t     strb;
  logic [NFLAG-1:0] flagQ;

  smbflag_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .evStartGen(evStartGen), .evStopGen(evStopGen), .evStartDet(evStartDet),
    .evRepStartDet(evRepStartDet), .evStopDet(evStopDet), .evAddrRcvd(evAddrRcvd),
    .evByteTxDone(evByteTxDone), .evByteRx(evByteRx), .evAckSampled(evAckSampled),
    .ackLevel(ackLevel), .evAckCycleEnd(evAckCycleEnd), .evFrameStart(evFrameStart),
    .sclLowOnGen(sclLowOnGen), .sdaLowOnTx1(sdaLowOnTx1), .dataWr(dataWr),
    .addressedSlave(addressedSlave), .hwAckEn(hwAckEn),
    .masterQ(flagQ[MST]), .startQ(flagQ[STA]), .strb(strb)
  );

  smbflag_regs u_regs (
    .clk(clk), .rst(rst), .strb(strb),
    .swWrEn(swWrEn), .swWrData(swWrData), .flagQ(flagQ)
  );

  assign flags   = flagQ;
  assign irq     = flagQ[SIF];
  assign sclHold = flagQ[SIF];

  // R2: generating a START always leaves master mode on
  p_master_on_r2: assert property (@(posedge clk) disable iff (rst)
    evStartGen |=> flags[MST]);

  // R6: an ACK cycle end with no new request leaves the ACK request off
  p_ackreq_off_r6: assert property (@(posedge clk) disable iff (rst)
    (evAckCycleEnd && !(evByteRx && !hwAckEn)) |=> !flags[AKR]);

  // R9: a sampled low ACK level is reported as acknowledge
  p_rxack_low_r9: assert property (@(posedge clk) disable iff (rst)
    (evAckSampled && !ackLevel) |=> flags[RXA]);
endmodule

// File: tb/smb_flag_tracker_bench.sv
module smb_flag_tracker_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evStartGen = 0, evStopGen = 0, evStartDet = 0, evRepStartDet = 0;
  logic evStopDet = 0, evAddrRcvd = 0, evByteTxDone = 0, evByteRx = 0;
  logic evAckSampled = 0, ackLevel = 0, evAckCycleEnd = 0, evFrameStart = 0;
  logic sclLowOnGen = 0, sdaLowOnTx1 = 0, dataWr = 0, addressedSlave = 0;
  logic hwAckEn = 0, swWrEn = 0;
  logic [7:0] swWrData = 8'h00;
  logic [7:0] flags;
  logic irq, sclHold;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  smb_flag_tracker u_smb_flag_tracker (
    .clk(clk), .rst(rst),
    .evStartGen(evStartGen), .evStopGen(evStopGen), .evStartDet(evStartDet),
    .evRepStartDet(evRepStartDet), .evStopDet(evStopDet), .evAddrRcvd(evAddrRcvd),
    .evByteTxDone(evByteTxDone), .evByteRx(evByteRx), .evAckSampled(evAckSampled),
    .ackLevel(ackLevel), .evAckCycleEnd(evAckCycleEnd), .evFrameStart(evFrameStart),
    .sclLowOnGen(sclLowOnGen), .sdaLowOnTx1(sdaLowOnTx1), .dataWr(dataWr),
    .addressedSlave(addressedSlave), .hwAckEn(hwAckEn),
    .swWrEn(swWrEn), .swWrData(swWrData),
    .flags(flags), .irq(irq), .sclHold(sclHold)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clearStrobes();
    evStartGen = 0; evStopGen = 0; evStartDet = 0; evRepStartDet = 0;
    evStopDet = 0; evAddrRcvd = 0; evByteTxDone = 0; evByteRx = 0;
    evAckSampled = 0; evAckCycleEnd = 0; evFrameStart = 0;
    sclLowOnGen = 0; sdaLowOnTx1 = 0; dataWr = 0; swWrEn = 0;
  endtask

  // strobes are set at a falling edge; one rising edge later the result is sampled
  task automatic tick();
    @(negedge clk);
    clearStrobes();
  endtask

  task automatic swWrite(input logic [7:0] v);
    swWrEn = 1; swWrData = v;
    tick();
  endtask

  task automatic t_reset();
    check("R1 flags after reset", flags, 8'h00);
    check("R1 irq/sclHold after reset", {6'b0, irq, sclHold}, 8'h00);
  endtask

  task automatic t_swWrite();
    swWrite(8'h55);
    check("R12 software load", flags, 8'h55);
    swWrite(8'h00);
    check("R12 software clear", flags, 8'h00);
  endtask

  task automatic t_master();
    evStartGen = 1; tick();
    check("R2 start generated", flags, 8'h83);
    check("R10 irq and sclHold follow interrupt", {6'b0, irq, sclHold}, 8'h03);
    swWrite(8'h03);
    sdaLowOnTx1 = 1; tick();
    check("R7 sda low on 1 loses arbitration, R2 master clears", flags, 8'hA0);
    swWrite(8'h20);
    check("R8 interrupt clear drops arbitration lost", flags, 8'h00);
    evStartGen = 1; tick();
    swWrite(8'h03);
    evStopGen = 1; tick();
    check("R2 stop generated clears master", flags, 8'h02);
    swWrite(8'h00);
  endtask

  task automatic t_txMode();
    dataWr = 1; tick();
    tick();
    evFrameStart = 1; tick();
    check("R3 earlier data write gives transmit", flags, 8'h02);
    evFrameStart = 1; tick();
    check("R3 no data write gives receive", flags, 8'h00);
    dataWr = 1; evFrameStart = 1; tick();
    check("R3 same-cycle data write gives transmit", flags, 8'h02);
    evStartDet = 1; tick();
    check("R3 detected START clears transmit", flags, 8'h00);
  endtask

  task automatic t_startFlag();
    evAddrRcvd = 1; tick();
    check("R4 address received sets start", flags, 8'h84);
    repeat (5) tick();
    check("R4 start stays until software", flags, 8'h84);
    swWrite(8'h00);
    check("R4 software clears start", flags, 8'h00);
  endtask

  task automatic t_stopFlag();
    addressedSlave = 0; evStopDet = 1; tick();
    check("R5 stop while not addressed", flags, 8'h80);
    swWrite(8'h00);
    addressedSlave = 1; evStopDet = 1; tick();
    check("R5 stop while addressed", flags, 8'h88);
    addressedSlave = 0;
    swWrite(8'h08);
    evStopGen = 1; tick();
    check("R5 stop generated clears stop", flags, 8'h00);
  endtask

  task automatic t_ackReq();
    hwAckEn = 1; evByteRx = 1; tick();
    check("R6 hardware ACK on, no request", flags, 8'h80);
    swWrite(8'h00);
    hwAckEn = 0; evByteRx = 1; tick();
    check("R6 hardware ACK off, request", flags, 8'h90);
    swWrite(8'h10);
    evAckCycleEnd = 1; tick();
    check("R6 ACK cycle end clears request", flags, 8'h00);
  endtask

  task automatic t_rxAck();
    evAckSampled = 1; ackLevel = 0; tick();
    check("R9 low level is acknowledge", flags, 8'h40);
    evAckSampled = 1; ackLevel = 1; tick();
    check("R9 high level is not acknowledge", flags, 8'h00);
    evByteTxDone = 1; tick();
    check("R10 byte transmitted sets interrupt", flags, 8'h80);
    swWrite(8'h00);
  endtask

  task automatic t_arb();
    swWrite(8'h01);
    evRepStartDet = 1; tick();
    check("R7 repeated START as master", flags, 8'hA0);
    swWrite(8'h00);
    swWrite(8'h05);
    evRepStartDet = 1; tick();
    check("R7 repeated START with start set is fine", flags, 8'h05);
    swWrite(8'h00);
    evRepStartDet = 1; tick();
    check("R7 repeated START when not master is fine", flags, 8'h00);
    sclLowOnGen = 1; tick();
    check("R7 SCL low while generating", flags, 8'hA0);
    swWrite(8'h00);
    check("R8 clear after SCL case", flags, 8'h00);
  endtask

  task automatic t_setWins();
    hwAckEn = 1; evByteRx = 1; tick();
    swWrEn = 1; swWrData = 8'h00; evByteTxDone = 1; tick();
    check("R11 interrupt set beats software clear", flags, 8'h80);
    sdaLowOnTx1 = 1; tick();
    swWrEn = 1; swWrData = 8'h00; sclLowOnGen = 1; tick();
    check("R11 arbitration set beats software clear", flags, 8'hA0);
    swWrite(8'h00);
    check("R11 final clear", flags, 8'h00);
    hwAckEn = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_swWrite();
    t_master();
    t_txMode();
    t_startFlag();
    t_stopFlag();
    t_ackReq();
    t_rxAck();
    t_arb();
    t_setWins();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule